// File: doc/BRIEF.md
# Cascaded Lookup-Engine Bring-Up Sequencer

This block sits on the host side of a chain of up to eight ternary lookup devices that share one request bus. A single start pulse makes it take the chain from power-up to normal operation without software. It holds the devices in reset. It then raises the identity chain input of the first device so that each device takes its position ID. After that it sends a fixed list of register and array writes through a four-beat write framer.

The write list has a set order. First comes a handshake-enable write to the final device. Then every device's data entries are zeroed and every mask entry is set to all ones. The optional global mask registers follow, then the reply-width registers. Last comes the per-device configuration word. That word is built at elaboration from the device's position in the chain and from the SRAM group boundaries, both of which are parameters. Devices are numbered 0 (highest priority) to NUM_DEV-1. A ready flag marks the end of the run. The block then waits until the next start pulse.

Top module: `cam_bringup_seq`

## Requirements
- R1: Before the first start, and for exactly RST_CYC cycles after a start is sampled, `dev_rst_no` and `id_chain_o` are low and `dev_strobe_o` stays low.
- R2: From the cycle in which `dev_rst_no` rises, `id_chain_o` is high and stays high. No strobe occurs for at least ID_CYC*NUM_DEV cycles after the release.
- R3: Every write is four beats long with `dev_cmd_o` = 7'b0000100. The first two beats have the strobe high and carry the header. The last two have the strobe low and carry the data. Writes in one run follow each other with no gap. Between runs, the command and request buses are zero.
- R4: The first write goes to register 0x03 (header bits [8:1]) of device NUM_DEV-1 (header bits [34:32] hold the target device ID in every write). Its data has only bit 28 set.
- R5: Data sweep: for each device in ascending order, every entry address from 0 to 2^ENTRY_AW-1 is written in ascending order. The header has address in bits [15:1], bits [25:24]=01 and bits [23:22]=11. The data is all zeros.
- R6: Mask sweep: after all data writes, the same walk is made with bits [25:24]=10 and data all ones.
- R7: With MASK_REG_EN set, each device in turn receives MASK_REG_VAL in MASK_REG_CNT global mask registers, in the address order 0x10–0x16, 0x20, 0x21, 0x24, 0x25, 0x30–0x33.
- R8: Each device then receives reply-width registers 0x04–0x07 in order. With REPLY_ID set, the data carries the device ID in bits [2:0], [26:24] and [50:48]; otherwise the data is zero.
- R9: Finally, each device in turn receives register 0x03. Bits 31 and 30 are set. Bit 29 is set only when GROUP_LAST marks the device as the last of its SRAM group. Bit 28 is set only for device NUM_DEV-1.
- R10: In that configuration word, bit 5+j of [11:5] is set for each device j that is in the target's group and is not the group's last device. Bits [1:0] equal PIPE_DLY. All other bits are zero.
- R11: `ready_o` rises in the cycle after the last beat of the final configuration write and stays high while idle. A start pulse during a run has no effect on it.
- R12: A start pulse while `ready_o` is high drops `ready_o` and `dev_rst_no` in the next cycle and repeats the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset of the sequencer |
| start_i | input | 1 | Start pulse; sampled only when idle or done |
| dev_rst_no | output | 1 | Active-low reset driven to all devices |
| dev_strobe_o | output | 1 | Request strobe, high during header beats |
| dev_cmd_o | output | 7 | Command bus |
| dev_req_o | output | 72 | Request bus, header then data |
| id_chain_o | output | 1 | Identity chain input of the first device |
| ready_o | output | 1 | Bring-up finished |

## Verification
The hardest point to reach is the joint between phases. The checks there are that the write sweeps run back to back with no idle beat, and that the configuration words of several groups come out in the right order. A bench with four devices in two groups and a small array depth reaches every phase boundary in a few hundred cycles. A scoreboard compares each framed write against a list the bench builds from the requirements. A start pulse in the middle of a run, and a restart from the done state, exercise the paths where a start must be ignored and where it must be honoured.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

   localparam int REQ_W = 72;
   localparam int CMD_W = 7;
   localparam int DEV_W = 3;

   localparam logic [CMD_W-1:0] OP_WRITE    = 7'b0000100;
   localparam logic [7:0]       ADDR_CFG    = 8'h03;
   localparam logic [7:0]       ADDR_REPLY0 = 8'h04;
   localparam int               LASTDEV_BIT = 28;

   typedef enum logic [3:0] {
      PH_IDLE, PH_RST, PH_CHAIN, PH_LC, PH_DATA, PH_MASK,
      PH_GMR, PH_RWR, PH_CFG, PH_DRAIN, PH_DONE
   } phase_t;

   // header selecting an internal register of one device
   function automatic logic [REQ_W-1:0] reg_hdr(input logic [7:0] a,
                                                input logic [DEV_W-1:0] d);
      logic [REQ_W-1:0] h;
      h        = '0;
      h[8:1]   = a;
      h[34:32] = d;
      return h;
   endfunction

   // header selecting a data (mask_sel=0) or mask (mask_sel=1) array entry
   function automatic logic [REQ_W-1:0] arr_hdr(input logic mask_sel,
                                                input logic [14:0] idx,
                                                input logic [DEV_W-1:0] d);
      logic [REQ_W-1:0] h;
      h          = '0;
      h[25:24]   = mask_sel ? 2'b10 : 2'b01;
      h[23:22]   = 2'b11;
      h[15:1]    = idx;
      h[34:32]   = d;
      return h;
   endfunction

   // address of the k-th global mask register
   function automatic logic [7:0] gmr_addr(input logic [3:0] k);
      if (k < 4'd7)       return 8'h10 + {4'd0, k};
      else if (k < 4'd9)  return 8'h20 + {4'd0, k - 4'd7};
      else if (k < 4'd11) return 8'h24 + {4'd0, k - 4'd9};
      else                return 8'h30 + {4'd0, k - 4'd11};
   endfunction

   // reply-width data carrying the device ID in the three width fields
   function automatic logic [REQ_W-1:0] reply_word(input logic [DEV_W-1:0] d);
      logic [REQ_W-1:0] w;
      w        = '0;
      w[2:0]   = d;
      w[26:24] = d;
      w[50:48] = d;
      return w;
   endfunction

endpackage

// File: rtl/bringup_framer.sv
module bringup_framer
   import bringup_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             go_i,
   input  logic [REQ_W-1:0] hdr_i,
   input  logic [REQ_W-1:0] dat_i,
   output logic             ready_o,
   output logic             last_o,
   output logic             strobe_o,
   output logic [CMD_W-1:0] cmd_o,
   output logic [REQ_W-1:0] req_o
);

   logic             act_q;
   logic [1:0]       beat_q;
   logic [REQ_W-1:0] hdr_q, dat_q;

   assign ready_o = !act_q || (beat_q == 2'd3);
   assign last_o  = act_q && (beat_q == 2'd3);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q  <= 1'b0;
         beat_q <= 2'd0;
         hdr_q  <= '0;
         dat_q  <= '0;
      end else if (go_i && ready_o) begin
         act_q  <= 1'b1;
         beat_q <= 2'd0;
         hdr_q  <= hdr_i;
         dat_q  <= dat_i;
      end else if (act_q) begin
         if (beat_q == 2'd3) act_q <= 1'b0;
         beat_q <= beat_q + 2'd1;
      end
   end

   assign strobe_o = act_q && !beat_q[1];
   assign cmd_o    = act_q ? OP_WRITE : '0;
   assign req_o    = !act_q ? '0 : (beat_q[1] ? dat_q : hdr_q);

   // R3: header beats come in pairs with a stable bus
   a_r3_hdr_pair : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(strobe_o) |=> (strobe_o && $stable(req_o)));
   // R3: the strobe drops after two header beats
   a_r3_strobe_two : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (strobe_o && $past(strobe_o)) |=> !strobe_o);

endmodule

// File: rtl/bringup_cfgtab.sv
module bringup_cfgtab
   import bringup_pkg::*;
#(
   parameter int         NUM_DEV    = 4,
   parameter logic [7:0] GROUP_LAST = 8'b0000_1000,
   parameter logic [1:0] PIPE_DLY   = 2'b00
) (
   input  logic [DEV_W-1:0] dev_idx_i,
   output logic [REQ_W-1:0] cfg_word_o
);

   localparam int SLOTS = 1 << DEV_W;

   function automatic logic [REQ_W-1:0] cfg_of(input int i);
      logic [REQ_W-1:0] w;
      int first, last;
      w     = '0;
      w[31] = 1'b1;
      w[30] = 1'b1;
      w[29] = GROUP_LAST[i];
      w[LASTDEV_BIT] = (i == NUM_DEV - 1);
      w[1:0] = PIPE_DLY;
      last  = NUM_DEV - 1;
      for (int j = NUM_DEV - 1; j >= 0; j--)
         if (j >= i && GROUP_LAST[j]) last = j;
      first = 0;
      for (int j = 0; j < NUM_DEV; j++)
         if (j < i && GROUP_LAST[j]) first = j + 1;
      for (int j = 0; j < 7; j++)
         if (j >= first && j < last) w[5 + j] = 1'b1;
      return w;
   endfunction

   logic [REQ_W-1:0] tbl [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      if (g < NUM_DEV) begin : g_dev
         assign tbl[g] = cfg_of(g);
      end else begin : g_none
         assign tbl[g] = '0;
      end
   end

   assign cfg_word_o = tbl[dev_idx_i];

endmodule

// File: rtl/bringup_ctl.sv
module bringup_ctl
   import bringup_pkg::*;
#(
   parameter int             NUM_DEV      = 4,
   parameter int             ENTRY_AW     = 15,
   parameter int             RST_CYC      = 32,
   parameter int             ID_CYC       = 16,
   parameter bit             MASK_REG_EN  = 1'b1,
   parameter int             MASK_REG_CNT = 15,
   parameter logic [REQ_W-1:0] MASK_REG_VAL = '1,
   parameter bit             REPLY_ID     = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             frm_ready_i,
   input  logic             frm_last_i,
   input  logic [REQ_W-1:0] cfg_word_i,
   output logic [DEV_W-1:0] dev_idx_o,
   output logic             go_o,
   output logic [REQ_W-1:0] hdr_o,
   output logic [REQ_W-1:0] dat_o,
   output logic             dev_rst_no,
   output logic             chain_o,
   output logic             ready_o
);

   localparam int CHAIN_CYC = ID_CYC * NUM_DEV;
   localparam int WAIT_MAX  = (RST_CYC > CHAIN_CYC) ? RST_CYC : CHAIN_CYC;
   localparam int CNT_W     = $clog2(WAIT_MAX + 1);
   localparam logic [DEV_W-1:0]    DEV_LAST = DEV_W'(NUM_DEV - 1);
   localparam logic [ENTRY_AW-1:0] ENT_LAST = '1;
   localparam logic [3:0]          GMR_LAST = 4'(MASK_REG_CNT - 1);
   localparam phase_t              AFTER_MASK = MASK_REG_EN ? PH_GMR : PH_RWR;

   phase_t              ph_q;
   logic [CNT_W-1:0]    cnt_q;
   logic [DEV_W-1:0]    dev_q;
   logic [ENTRY_AW-1:0] ent_q;
   logic [3:0]          reg_q;
   logic                want;

   assign want = (ph_q == PH_LC) || (ph_q == PH_DATA) || (ph_q == PH_MASK) ||
                 (ph_q == PH_GMR) || (ph_q == PH_RWR) || (ph_q == PH_CFG);
   assign go_o       = want && frm_ready_i;
   assign dev_idx_o  = dev_q;
   assign dev_rst_no = !((ph_q == PH_IDLE) || (ph_q == PH_RST));
   assign chain_o    = dev_rst_no;
   assign ready_o    = (ph_q == PH_DONE);

   always_comb begin
      hdr_o = '0;
      dat_o = '0;
      unique case (ph_q)
         PH_LC: begin
            hdr_o = reg_hdr(ADDR_CFG, DEV_LAST);
            dat_o[LASTDEV_BIT] = 1'b1;
         end
         PH_DATA: hdr_o = arr_hdr(1'b0, 15'(ent_q), dev_q);
         PH_MASK: begin
            hdr_o = arr_hdr(1'b1, 15'(ent_q), dev_q);
            dat_o = '1;
         end
         PH_GMR: begin
            hdr_o = reg_hdr(gmr_addr(reg_q), dev_q);
            dat_o = MASK_REG_VAL;
         end
         PH_RWR: begin
            hdr_o = reg_hdr(ADDR_REPLY0 + {4'd0, reg_q}, dev_q);
            dat_o = REPLY_ID ? reply_word(dev_q) : '0;
         end
         PH_CFG: begin
            hdr_o = reg_hdr(ADDR_CFG, dev_q);
            dat_o = cfg_word_i;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
         dev_q <= '0;
         ent_q <= '0;
         reg_q <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE, PH_DONE: if (start_i) begin
               ph_q  <= PH_RST;
               cnt_q <= '0;
            end
            PH_RST: if (cnt_q == CNT_W'(RST_CYC - 1)) begin
               ph_q  <= PH_CHAIN;
               cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
            PH_CHAIN: if (cnt_q == CNT_W'(CHAIN_CYC - 1)) begin
               ph_q  <= PH_LC;
               cnt_q <= '0;
            end else cnt_q <= cnt_q + 1'b1;
            PH_LC: if (go_o) begin
               ph_q  <= PH_DATA;
               dev_q <= '0;
               ent_q <= '0;
            end
            PH_DATA, PH_MASK: if (go_o) begin
               if (ent_q == ENT_LAST) begin
                  ent_q <= '0;
                  if (dev_q == DEV_LAST) begin
                     dev_q <= '0;
                     reg_q <= '0;
                     ph_q  <= (ph_q == PH_DATA) ? PH_MASK : AFTER_MASK;
                  end else dev_q <= dev_q + 1'b1;
               end else ent_q <= ent_q + 1'b1;
            end
            PH_GMR, PH_RWR: if (go_o) begin
               if (reg_q == ((ph_q == PH_GMR) ? GMR_LAST : 4'd3)) begin
                  reg_q <= '0;
                  if (dev_q == DEV_LAST) begin
                     dev_q <= '0;
                     ph_q  <= (ph_q == PH_GMR) ? PH_RWR : PH_CFG;
                  end else dev_q <= dev_q + 1'b1;
               end else reg_q <= reg_q + 1'b1;
            end
            PH_CFG: if (go_o) begin
               if (dev_q == DEV_LAST) begin
                  dev_q <= '0;
                  ph_q  <= PH_DRAIN;
               end else dev_q <= dev_q + 1'b1;
            end
            PH_DRAIN: if (frm_last_i) ph_q <= PH_DONE;
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   // R2: no write is launched while the chain is in reset or unidentified
   a_r2_write_after_chain : assert property (@(posedge clk_i) disable iff (!rst_ni)
      go_o |-> (dev_rst_no && chain_o));
   // R12: a start while done restarts the reset phase
   a_r12_restart : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_o && start_i) |=> (!dev_rst_no && !ready_o));

endmodule

// File: rtl/cam_bringup_seq.sv
module cam_bringup_seq
   import bringup_pkg::*;
#(
   parameter int               NUM_DEV      = 4,
   parameter int               ENTRY_AW     = 15,
   parameter int               RST_CYC      = 32,
   parameter int               ID_CYC       = 16,
   parameter bit               MASK_REG_EN  = 1'b1,
   parameter int               MASK_REG_CNT = 15,
   parameter logic [REQ_W-1:0] MASK_REG_VAL = '1,
   parameter bit               REPLY_ID     = 1'b1,
   parameter logic [7:0]       GROUP_LAST   = 8'b0000_1000,
   parameter logic [1:0]       PIPE_DLY     = 2'b00
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   output logic             dev_rst_no,
   output logic             dev_strobe_o,
   output logic [CMD_W-1:0] dev_cmd_o,
   output logic [REQ_W-1:0] dev_req_o,
   output logic             id_chain_o,
   output logic             ready_o
);

   if (NUM_DEV < 1 || NUM_DEV > 8) begin : g_bad_num_dev
      $error("NUM_DEV must lie in 1..8");
   end
   if (ENTRY_AW < 1 || ENTRY_AW > 15) begin : g_bad_entry_aw
      $error("ENTRY_AW must lie in 1..15");
   end
   if (MASK_REG_CNT < 1 || MASK_REG_CNT > 15) begin : g_bad_gmr_cnt
      $error("MASK_REG_CNT must lie in 1..15");
   end
   if (RST_CYC < 1 || ID_CYC < 1) begin : g_bad_wait
      $error("RST_CYC and ID_CYC must be positive");
   end
   if (!GROUP_LAST[NUM_DEV-1]) begin : g_bad_groups
      $error("the final device must close an SRAM group");
   end

   logic             frm_ready, frm_last, go;
   logic [REQ_W-1:0] hdr, dat, cfg_word;
   logic [DEV_W-1:0] dev_idx;

   bringup_ctl #(
      .NUM_DEV(NUM_DEV), .ENTRY_AW(ENTRY_AW), .RST_CYC(RST_CYC),
      .ID_CYC(ID_CYC), .MASK_REG_EN(MASK_REG_EN), .MASK_REG_CNT(MASK_REG_CNT),
      .MASK_REG_VAL(MASK_REG_VAL), .REPLY_ID(REPLY_ID)
   ) ctl_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
      .frm_ready_i(frm_ready), .frm_last_i(frm_last), .cfg_word_i(cfg_word),
      .dev_idx_o(dev_idx), .go_o(go), .hdr_o(hdr), .dat_o(dat),
      .dev_rst_no(dev_rst_no), .chain_o(id_chain_o), .ready_o(ready_o)
   );

   bringup_cfgtab #(
      .NUM_DEV(NUM_DEV), .GROUP_LAST(GROUP_LAST), .PIPE_DLY(PIPE_DLY)
   ) cfg_i (
      .dev_idx_i(dev_idx), .cfg_word_o(cfg_word)
   );

   bringup_framer frm_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .go_i(go), .hdr_i(hdr), .dat_i(dat),
      .ready_o(frm_ready), .last_o(frm_last), .strobe_o(dev_strobe_o),
      .cmd_o(dev_cmd_o), .req_o(dev_req_o)
   );

   // R1: the strobe is quiet while the devices are held in reset
   a_r1_quiet_in_reset : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dev_rst_no |-> !dev_strobe_o);
   // R11: once done the buses stay idle
   a_r11_idle_when_ready : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |-> (!dev_strobe_o && dev_req_o == '0 && dev_cmd_o == '0));

endmodule

// File: tb/cam_bringup_seq_tb_top.sv
module cam_bringup_seq_tb_top;

   localparam int          N      = 4;
   localparam int          AW     = 3;
   localparam logic [71:0] GVAL   = 72'hA5_0123_4567_89AB_CDEF;
   localparam logic [7:0]  GLAST  = 8'b0000_1010;
   localparam logic [1:0]  PD     = 2'b01;

   logic        clk = 1'b0;
   logic        rst_n, start;
   logic        dev_rst_n, strobe, chain, ready;
   logic [6:0]  cmd;
   logic [71:0] req;

   always #4 clk = ~clk;

   cam_bringup_seq #(
      .NUM_DEV(N), .ENTRY_AW(AW), .RST_CYC(32), .ID_CYC(16),
      .MASK_REG_EN(1'b1), .MASK_REG_CNT(15), .MASK_REG_VAL(GVAL),
      .REPLY_ID(1'b1), .GROUP_LAST(GLAST), .PIPE_DLY(PD)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start),
      .dev_rst_no(dev_rst_n), .dev_strobe_o(strobe), .dev_cmd_o(cmd),
      .dev_req_o(req), .id_chain_o(chain), .ready_o(ready)
   );

   typedef struct { logic [71:0] h; logic [71:0] d; string tag; } exp_t;
   exp_t q[$];
   int   n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string tag,
                      input logic [71:0] act, input logic [71:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   function automatic logic [71:0] e_reg(input int a, input int d);
      logic [71:0] h = '0;
      h[8:1]   = a[7:0];
      h[34:32] = d[2:0];
      return h;
   endfunction

   function automatic logic [71:0] e_arr(input bit m, input int i, input int d);
      logic [71:0] h = '0;
      h[25:24] = m ? 2'b10 : 2'b01;
      h[23:22] = 2'b11;
      h[15:1]  = i[14:0];
      h[34:32] = d[2:0];
      return h;
   endfunction

   int gmr_tab[15] = '{'h10, 'h11, 'h12, 'h13, 'h14, 'h15, 'h16,
                       'h20, 'h21, 'h24, 'h25, 'h30, 'h31, 'h32, 'h33};

   task automatic push(input logic [71:0] h, input logic [71:0] d, input string t);
      exp_t e;
      e.h = h; e.d = d; e.tag = t;
      q.push_back(e);
   endtask

   // driver side of the scoreboard: expected write list from the requirements
   task automatic fill();
      logic [71:0] d;
      d = '0; d[28] = 1'b1;
      push(e_reg('h03, N - 1), d, "R4 handshake enable");
      for (int dv = 0; dv < N; dv++)
         for (int i = 0; i < (1 << AW); i++)
            push(e_arr(1'b0, i, dv), '0, "R5 data sweep");
      for (int dv = 0; dv < N; dv++)
         for (int i = 0; i < (1 << AW); i++)
            push(e_arr(1'b1, i, dv), '1, "R6 mask sweep");
      for (int dv = 0; dv < N; dv++)
         for (int k = 0; k < 15; k++)
            push(e_reg(gmr_tab[k], dv), GVAL, "R7 mask register");
      for (int dv = 0; dv < N; dv++)
         for (int k = 0; k < 4; k++) begin
            d = '0;
            d[2:0] = 3'(dv); d[26:24] = 3'(dv); d[50:48] = 3'(dv);
            push(e_reg(4 + k, dv), d, "R8 reply width");
         end
      for (int dv = 0; dv < N; dv++) begin
         int gfirst, glast;
         glast = N - 1;
         for (int j = N - 1; j >= dv; j--) if (GLAST[j]) glast = j;
         gfirst = 0;
         for (int j = 0; j < dv; j++) if (GLAST[j]) gfirst = j + 1;
         d = '0;
         d[31] = 1'b1; d[30] = 1'b1;
         d[29] = (dv == glast);
         d[28] = (dv == N - 1);
         for (int j = gfirst; j < glast; j++) d[5 + j] = 1'b1;
         d[1:0] = PD;
         push(e_reg('h03, dv), d, "R9 R10 config word");
      end
   endtask

   // monitor side of the scoreboard
   int          mbeat = 0;
   bit          in_burst = 0, exp_ready = 0;
   logic [71:0] cur_h, cur_d;

   always @(negedge clk) if (rst_n) begin
      if (exp_ready) begin
         chk(ready, "R11 ready after final write", {71'd0, ready}, 72'd1);
         exp_ready = 0;
      end
      case (mbeat)
         0: if (strobe) begin
               cur_h = req;
               chk(cmd == 7'b0000100, "R3 write opcode", {65'd0, cmd}, 72'd4);
               mbeat = 1;
            end else begin
               chk(!in_burst, "R3 back-to-back frames", 72'd1, 72'd0);
               chk(req == '0 && cmd == '0, "R3 idle bus", req, '0);
               in_burst = 0;
            end
         1: begin
               chk(strobe && req == cur_h, "R3 second header beat", req, cur_h);
               mbeat = 2;
            end
         2: begin
               chk(!strobe && cmd == 7'b0000100, "R3 first data beat",
                   {71'd0, strobe}, 72'd0);
               cur_d = req;
               mbeat = 3;
            end
         default: begin
               chk(!strobe && req == cur_d, "R3 second data beat", req, cur_d);
               mbeat = 0;
               if (q.size() == 0) begin
                  chk(1'b0, "R3 unexpected write", cur_h, '0);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  chk(cur_h == e.h, {e.tag, " header"}, cur_h, e.h);
                  chk(cur_d == e.d, {e.tag, " data"}, cur_d, e.d);
               end
               in_burst  = (q.size() > 0);
               exp_ready = (q.size() == 0);
            end
      endcase
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == 60000) begin
         chk(1'b0, "watchdog expired", 72'(cyc), 72'd0);
         summary();
         $finish;
      end
   end

   task automatic run(input bit poke);
      int n, m;
      fill();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!ready && !dev_rst_n, "R12 start drops ready and reset",
          {70'd0, ready, dev_rst_n}, 72'd0);
      n = 0;
      while (!dev_rst_n) begin
         chk(!strobe && !chain, "R1 quiet during reset", {70'd0, strobe, chain}, 72'd0);
         n++;
         @(negedge clk);
      end
      chk(n == 32, "R1 reset length", 72'(n), 72'd32);
      m = 0;
      while (!strobe) begin
         chk(chain, "R2 chain held high", {71'd0, chain}, 72'd1);
         m++;
         @(negedge clk);
      end
      chk(m >= 16 * N, "R2 identity wait", 72'(m), 72'(16 * N));
      if (poke) begin
         repeat (20) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         chk(dev_rst_n && !ready, "R11 start ignored mid-run",
             {70'd0, dev_rst_n, ready}, 72'd2);
      end
      while (!ready) @(negedge clk);
      chk(q.size() == 0, "R11 all writes seen before ready", 72'(q.size()), 72'd0);
      repeat (3) begin
         @(negedge clk);
         chk(ready && dev_rst_n && chain, "R11 ready holds",
             {69'd0, ready, dev_rst_n, chain}, 72'd7);
      end
   endtask

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      repeat (3) @(negedge clk);
      chk(!dev_rst_n && !strobe && !chain && !ready && req == '0 && cmd == '0,
          "R1 reset state", {68'd0, dev_rst_n, strobe, chain, ready}, 72'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(!dev_rst_n && !chain, "R1 held before first start",
          {70'd0, dev_rst_n, chain}, 72'd0);
      run(1'b1);
      run(1'b0);
      summary();
      $finish;
   end

endmodule